// File: doc/BRIEF.md
# NAND Reset and Identification Controller

This block brings an attached NAND flash device out of reset and identifies it. After a start pulse it issues the reset command on the shared command strobe and waits a fixed time. It then polls the device status until the two ready bits are both set. With extended checking selected, polling is paced and bounded, and it gives up with a timeout code. Without it, the block polls back to back for as long as the device stays busy.

Once the device is ready, the block issues the identify command and one zero address byte, then reads five data bytes. The first two bytes must match the single supported maker and device code. The fourth byte carries the geometry fields. The block decodes them and accepts only the supported page, spare and block sizes. On success it presents the address shift amounts and the full geometry for use by the page operation sequencer. In every case it raises `done` together with a result code.

Top module: `nand_id_probe`

## Requirements
- R1: After reset, `done` is low, all three bus strobes are low, `result` is 0 and every geometry output is zero.
- R2: When the block is idle or finished, `start` causes the reset command 0xFF to be driven on `wr_byte` with `cmd_we` in the next cycle. A `start` that arrives while a probe is running is ignored.
- R3: The first status command 0x70 is issued exactly RST_CYC+1 cycles after the reset command, where RST_CYC = CLK_KHZ*RESET_US/1000.
- R4: Each status command is followed in the next cycle by one `data_re` read. The device counts as ready only when `rd_data` bits 6 and 5 are both 1. A status of 0x20 (bit 5 only) is not ready.
- R5: With `ext_verify` high at start, consecutive status commands are POLL_CYC+2 cycles apart. After POLL_LIMIT+1 not-ready reads the block finishes with result 1 (reset timeout) and never issues the identify command.
- R6: With `ext_verify` low, a not-ready read is followed 2 cycles later by a new status command, with no limit on the number of polls.
- R7: After ready, the block issues identify command 0x90, then one `addr_we` cycle with byte 0x00, then exactly five `data_re` reads.
- R8: If byte 0 is not 0x2C or byte 1 is not 0xBA, the result is 2 (unsupported part) and all geometry outputs are zero. The ID check is made before the geometry check.
- R9: Byte 3 carries the geometry fields. Bits 1:0 give the page size, 1 KB shifted left by the field. Bit 2 gives the spare size, 16 bytes (when 1) or 8 bytes (when 0) per 512 data bytes. Bits 5:4 give the block size, 64 KB shifted left by the field. Anything other than a 2048-byte page, a 64-byte spare area and a 131072-byte block gives result 3 (bad geometry) with geometry outputs zero.
- R10: On success, the result is 0 and the outputs are: block shift 17, page shift 11, page 2048, spare 64, block 131072, 64 pages per block, 4 ECC chunks of 512 bytes, and `bus_x16` equal to byte 3 bit 6.
- R11: `done` and all result outputs hold steady, and no strobe is driven, until the next `start`.
- R12: At most one of `cmd_we`, `addr_we`, `data_re` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reset-and-identify probe |
| ext_verify | input | 1 | Bounded, paced status polling when high (sampled at start) |
| rd_data | input | 8 | Byte returned by the device during a `data_re` cycle |
| cmd_we | output | 1 | Command byte strobe |
| addr_we | output | 1 | Address byte strobe |
| data_re | output | 1 | Data read strobe |
| wr_byte | output | 8 | Command or address byte |
| done | output | 1 | Probe finished |
| result | output | 2 | 0 ok, 1 reset timeout, 2 unsupported part, 3 bad geometry |
| blk_shift | output | 5 | Block address shift |
| pg_shift | output | 5 | Page address shift |
| page_bytes | output | 16 | Page size in bytes |
| spare_bytes | output | 9 | Spare area size in bytes |
| block_bytes | output | 20 | Block size in bytes |
| pages_per_blk | output | 10 | Pages in one block |
| ecc_chunks | output | 5 | 512-byte ECC chunks per page |
| bus_x16 | output | 1 | Device bus is 16 bits wide |

## Verification
The bench measures the cycle distance from the reset command to the first status command, and between successive polls in both polling modes. A design with an off-by-one wait counter, or one that paces polls when it should not, shows a wrong gap. It drives a status of 0x20 to catch a design that tests only one ready bit. It runs the bounded mode past its limit to catch a timeout that fires one poll early or late, or that goes on to identify anyway. Byte patterns with one bad field at a time, and an unsupported ID paired with bad geometry, expose swapped field positions and a wrong check priority.

// File: rtl/nip_pkg.sv
package nip_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_RST_CMD, S_RST_WAIT, S_ST_CMD, S_ST_READ,
        S_POLL_WAIT, S_ID_CMD, S_ID_ADDR, S_ID_READ, S_DONE
    } nip_state_e;

    typedef enum logic [1:0] {
        RES_OK          = 2'd0,
        RES_RST_TIMEOUT = 2'd1,
        RES_UNSUPPORTED = 2'd2,
        RES_BAD_GEOM    = 2'd3
    } nip_result_e;

    localparam logic [7:0] OP_RESET   = 8'hFF;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_READ_ID = 8'h90;
    localparam logic [7:0] ID_ADDR_B  = 8'h00;

    typedef struct packed {
        logic [15:0] page_bytes;
        logic [8:0]  spare_bytes;
        logic [19:0] block_bytes;
        logic [9:0]  pages_per_blk;
        logic [4:0]  ecc_chunks;
        logic        x16;
    } nip_geom_t;

endpackage

// File: rtl/nip_geom_decode.sv
module nip_geom_decode
    import nip_pkg::*;
#(
    parameter int SUP_PAGE  = 2048,
    parameter int SUP_SPARE = 64,
    parameter int SUP_BLOCK = 131072
) (
    input  logic [7:0] id_byte,
    output nip_geom_t  geom,
    output logic       fits
);
    logic [1:0] pg_sel;
    logic [1:0] blk_sel;
    logic [3:0] pg_log2;

    always_comb begin
        pg_sel  = id_byte[1:0];
        blk_sel = id_byte[5:4];
        pg_log2 = {2'b00, pg_sel} + 4'd10;
        geom.page_bytes    = 16'd1024 << pg_sel;
        geom.ecc_chunks    = 5'(geom.page_bytes >> 9);
        geom.spare_bytes   = id_byte[2] ? {geom.ecc_chunks, 4'b0000}
                                        : {1'b0, geom.ecc_chunks, 3'b000};
        geom.block_bytes   = 20'd65536 << blk_sel;
        geom.pages_per_blk = 10'(geom.block_bytes >> pg_log2);
        geom.x16           = id_byte[6];
        fits = (geom.page_bytes  == 16'(SUP_PAGE))
            && (geom.spare_bytes == 9'(SUP_SPARE))
            && (geom.block_bytes == 20'(SUP_BLOCK));
    end
endmodule

// File: rtl/nip_delay.sv
module nip_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nand_id_probe.sv
module nand_id_probe
    import nip_pkg::*;
#(
    parameter int         CLK_KHZ    = 100000,
    parameter int         RESET_US   = 1000,
    parameter int         POLL_US    = 50,
    parameter int         POLL_LIMIT = 20000,
    parameter logic [7:0] MFR_ID     = 8'h2C,
    parameter logic [7:0] DEV_ID     = 8'hBA,
    parameter int         BLK_SHIFT  = 17,
    parameter int         PG_SHIFT   = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        ext_verify,
    input  logic [7:0]  rd_data,
    output logic        cmd_we,
    output logic        addr_we,
    output logic        data_re,
    output logic [7:0]  wr_byte,
    output logic        done,
    output logic [1:0]  result,
    output logic [4:0]  blk_shift,
    output logic [4:0]  pg_shift,
    output logic [15:0] page_bytes,
    output logic [8:0]  spare_bytes,
    output logic [19:0] block_bytes,
    output logic [9:0]  pages_per_blk,
    output logic [4:0]  ecc_chunks,
    output logic        bus_x16
);
    localparam int RST_CYC  = CLK_KHZ * RESET_US / 1000;
    localparam int POLL_CYC = CLK_KHZ * POLL_US / 1000;
    localparam int MAX_CYC  = (RST_CYC > POLL_CYC) ? RST_CYC : POLL_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);
    localparam int PW       = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        nip_state_e  st;
        logic        ext;
        logic [PW-1:0] polls;
        logic [2:0]  idx;
        logic [7:0]  mfr;
        logic [7:0]  dev;
        logic [7:0]  geo;
        logic        done;
        nip_result_e res;
        nip_geom_t   geom;
        logic [4:0]  bsh;
        logic [4:0]  psh;
    } probe_t;

    probe_t        d, q;
    logic          tmr_load, tmr_zero, ready;
    logic [TW-1:0] tmr_val;
    nip_geom_t     dec;
    logic          dec_fits;
    logic          idle_w;

    nip_delay #(.W(TW)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
    );

    nip_geom_decode u_geom (.id_byte(q.geo), .geom(dec), .fits(dec_fits));

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ready    = rd_data[6] & rd_data[5];
        case (q.st)
            S_IDLE, S_DONE: if (start) begin
                d.st    = S_RST_CMD;
                d.done  = 1'b0;
                d.res   = RES_OK;
                d.geom  = '0;
                d.bsh   = '0;
                d.psh   = '0;
                d.ext   = ext_verify;
                d.polls = '0;
            end
            S_RST_CMD: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(RST_CYC - 1);
                d.st     = S_RST_WAIT;
            end
            S_RST_WAIT:  if (tmr_zero) d.st = S_ST_CMD;
            S_ST_CMD:    d.st = S_ST_READ;
            S_ST_READ: begin
                if (ready)
                    d.st = S_ID_CMD;
                else if (!q.ext)
                    d.st = S_ST_CMD;
                else if (q.polls == PW'(POLL_LIMIT)) begin
                    d.st   = S_DONE;
                    d.done = 1'b1;
                    d.res  = RES_RST_TIMEOUT;
                end else begin
                    d.polls  = q.polls + 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(POLL_CYC - 1);
                    d.st     = S_POLL_WAIT;
                end
            end
            S_POLL_WAIT: if (tmr_zero) d.st = S_ST_CMD;
            S_ID_CMD:    d.st = S_ID_ADDR;
            S_ID_ADDR: begin
                d.idx = '0;
                d.st  = S_ID_READ;
            end
            S_ID_READ: begin
                d.idx = q.idx + 1'b1;
                case (q.idx)
                    3'd0:    d.mfr = rd_data;
                    3'd1:    d.dev = rd_data;
                    3'd3:    d.geo = rd_data;
                    default: ;
                endcase
                if (q.idx == 3'd4) begin
                    d.st   = S_DONE;
                    d.done = 1'b1;
                    if (q.mfr != MFR_ID || q.dev != DEV_ID)
                        d.res = RES_UNSUPPORTED;
                    else if (!dec_fits)
                        d.res = RES_BAD_GEOM;
                    else begin
                        d.res  = RES_OK;
                        d.geom = dec;
                        d.bsh  = 5'(BLK_SHIFT);
                        d.psh  = 5'(PG_SHIFT);
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= S_IDLE;
            q.res <= RES_OK;
        end else begin
            q <= d;
        end
    end

    assign idle_w  = (q.st == S_IDLE) || (q.st == S_DONE);
    assign cmd_we  = (q.st == S_RST_CMD) || (q.st == S_ST_CMD) || (q.st == S_ID_CMD);
    assign addr_we = (q.st == S_ID_ADDR);
    assign data_re = (q.st == S_ST_READ) || (q.st == S_ID_READ);
    assign wr_byte = (q.st == S_RST_CMD) ? OP_RESET  :
                     (q.st == S_ST_CMD)  ? OP_STATUS :
                     (q.st == S_ID_CMD)  ? OP_READ_ID : ID_ADDR_B;
    assign done          = q.done;
    assign result        = q.res;
    assign blk_shift     = q.bsh;
    assign pg_shift      = q.psh;
    assign page_bytes    = q.geom.page_bytes;
    assign spare_bytes   = q.geom.spare_bytes;
    assign block_bytes   = q.geom.block_bytes;
    assign pages_per_blk = q.geom.pages_per_blk;
    assign ecc_chunks    = q.geom.ecc_chunks;
    assign bus_x16       = q.geom.x16;
endmodule

// File: rtl/nip_checker.sv
module nip_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        idle,
    input logic        cmd_we,
    input logic        addr_we,
    input logic        data_re,
    input logic [7:0]  wr_byte,
    input logic        done,
    input logic [1:0]  result,
    input logic [15:0] page_bytes,
    input logic [19:0] block_bytes,
    input logic [9:0]  pages_per_blk,
    input logic [4:0]  ecc_chunks
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cmd_we, addr_we, data_re}) <= 1); // R12
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(cmd_we || addr_we || data_re)); // R11
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(result) && $stable(page_bytes) && $stable(block_bytes)); // R11
    AST_START_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        idle && start |=> cmd_we && wr_byte == 8'hFF); // R2
    AST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we |-> wr_byte == 8'h00); // R7
    AST_GEOM_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == 2'd0 |-> (32'(pages_per_blk) * 32'(page_bytes) == 32'(block_bytes))
                                   && (32'(ecc_chunks) * 32'd512 == 32'(page_bytes))); // R10
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done && result != 2'd0 |-> page_bytes == 16'd0 && block_bytes == 20'd0); // R8
endmodule

bind nand_id_probe nip_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle_w),
    .cmd_we(cmd_we), .addr_we(addr_we), .data_re(data_re), .wr_byte(wr_byte),
    .done(done), .result(result), .page_bytes(page_bytes), .block_bytes(block_bytes),
    .pages_per_blk(pages_per_blk), .ecc_chunks(ecc_chunks)
);

// File: tb/sim_nand_id_probe.sv
`timescale 1ns/1ps
module sim_nand_id_probe;
    localparam int LIMIT = 4;
    localparam int RSTC  = 1000;
    localparam int POLLC = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ext_verify = 1'b0;
    logic [7:0] rd_data;
    logic cmd_we, addr_we, data_re, done, bus_x16;
    logic [7:0] wr_byte;
    logic [1:0] result;
    logic [4:0] blk_shift, pg_shift, ecc_chunks;
    logic [15:0] page_bytes;
    logic [8:0] spare_bytes;
    logic [19:0] block_bytes;
    logic [9:0] pages_per_blk;

    always #5 clk = ~clk;

    nand_id_probe #(.CLK_KHZ(1000), .RESET_US(1000), .POLL_US(50), .POLL_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_verify(ext_verify), .rd_data(rd_data),
        .cmd_we(cmd_we), .addr_we(addr_we), .data_re(data_re), .wr_byte(wr_byte),
        .done(done), .result(result), .blk_shift(blk_shift), .pg_shift(pg_shift),
        .page_bytes(page_bytes), .spare_bytes(spare_bytes), .block_bytes(block_bytes),
        .pages_per_blk(pages_per_blk), .ecc_chunks(ecc_chunks), .bus_x16(bus_x16)
    );

    // device model and bus log
    logic [7:0] idb [5];
    int busy_n = 0;
    logic clr = 1'b0;
    logic [7:0] last_cmd = 8'h00;
    int cyc = 0, rst_at = 0, prev_st = 0, first_gap = 0, last_gap = 0;
    int n_st = 0, n_rst = 0, n_id = 0, n_addr = 0, n_idrd = 0, n_strobe = 0, rd_idx = 0;
    logic [7:0] addr_val = 8'hFF;

    assign rd_data = (last_cmd == 8'h70) ? ((n_st > busy_n) ? 8'hE0 : 8'h20) :
                     (last_cmd == 8'h90 && rd_idx < 5) ? idb[rd_idx] : 8'h00;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr) begin
            n_st <= 0; n_rst <= 0; n_id <= 0; n_addr <= 0; n_idrd <= 0;
            n_strobe <= 0; rd_idx <= 0; first_gap <= 0; last_gap <= 0;
            last_cmd <= 8'h00; addr_val <= 8'hFF;
        end else begin
            if (cmd_we || addr_we || data_re) n_strobe <= n_strobe + 1;
            if (cmd_we) begin
                last_cmd <= wr_byte;
                if (wr_byte == 8'hFF) begin n_rst <= n_rst + 1; rst_at <= cyc; end
                if (wr_byte == 8'h70) begin
                    if (n_st == 0) first_gap <= cyc - rst_at;
                    else last_gap <= cyc - prev_st;
                    prev_st <= cyc;
                    n_st <= n_st + 1;
                end
                if (wr_byte == 8'h90) begin n_id <= n_id + 1; rd_idx <= 0; end
            end
            if (addr_we) begin n_addr <= n_addr + 1; addr_val <= wr_byte; end
            if (data_re && last_cmd == 8'h90) begin
                n_idrd <= n_idrd + 1; rd_idx <= rd_idx + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    logic wd_hit = 1'b0;

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input logic ext, input int busy, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b3, input logic extra_start);
        @(negedge clk);
        clr = 1'b1; busy_n = busy;
        idb[0] = b0; idb[1] = b1; idb[2] = 8'h00; idb[3] = b3; idb[4] = 8'h00;
        @(negedge clk);
        clr = 1'b0; ext_verify = ext; start = 1'b1;
        @(negedge clk);
        start = 1'b0; ext_verify = ~ext;
        if (extra_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    endtask

    task automatic chk_zero_geom(input string req);
        chk(page_bytes == 0 && block_bytes == 0 && spare_bytes == 0 && blk_shift == 0 && pg_shift == 0,
            req, page_bytes, 0);
    endtask

    task automatic t_reset_state();
        chk(done == 1'b0, "R1 done", done, 0);
        chk(!cmd_we && !addr_we && !data_re, "R1 strobes", {cmd_we, addr_we, data_re}, 0);
        chk(result == 2'd0, "R1 result", result, 0);
        chk_zero_geom("R1 geometry");
    endtask

    task automatic t_good_x8();
        run(1'b1, 2, 8'h2C, 8'hBA, 8'h15, 1'b1);
        chk(done == 1'b1, "R10 done", done, 1);
        chk(result == 2'd0, "R10 result", result, 0);
        chk(n_rst == 1, "R2 extra start ignored", n_rst, 1);
        chk(first_gap == RSTC + 1, "R3 reset wait", first_gap, RSTC + 1);
        chk(last_gap == POLLC + 2, "R5 poll pacing", last_gap, POLLC + 2);
        chk(n_st == 3, "R4 status polls", n_st, 3);
        chk(n_id == 1 && n_addr == 1 && addr_val == 8'h00, "R7 id cmd/addr", n_addr, 1);
        chk(n_idrd == 5, "R7 id reads", n_idrd, 5);
        chk(blk_shift == 17 && pg_shift == 11, "R10 shifts", {blk_shift, pg_shift}, {5'd17, 5'd11});
        chk(page_bytes == 2048, "R10 page", page_bytes, 2048);
        chk(spare_bytes == 64, "R10 spare", spare_bytes, 64);
        chk(block_bytes == 131072, "R10 block", block_bytes, 131072);
        chk(pages_per_blk == 64, "R10 pages per block", pages_per_blk, 64);
        chk(ecc_chunks == 4, "R10 ecc chunks", ecc_chunks, 4);
        chk(bus_x16 == 1'b0, "R10 x8", bus_x16, 0);
    endtask

    task automatic t_hold();
        int s0 = n_strobe;
        repeat (30) @(negedge clk);
        chk(done && result == 2'd0 && page_bytes == 2048, "R11 held", result, 0);
        chk(n_strobe == s0, "R11 bus quiet", n_strobe, s0);
    endtask

    task automatic t_good_x16_nolimit();
        run(1'b0, 10, 8'h2C, 8'hBA, 8'h55, 1'b0);
        chk(result == 2'd0, "R6 unbounded poll result", result, 0);
        chk(n_st == 11, "R6 poll count", n_st, 11);
        chk(last_gap == 2, "R6 poll gap", last_gap, 2);
        chk(bus_x16 == 1'b1, "R10 x16", bus_x16, 1);
    endtask

    task automatic t_timeout();
        run(1'b1, 1000, 8'h2C, 8'hBA, 8'h15, 1'b0);
        chk(done && result == 2'd1, "R5 timeout result", result, 1);
        chk(n_st == LIMIT + 1, "R5 timeout poll count", n_st, LIMIT + 1);
        chk(n_id == 0, "R5 no identify", n_id, 0);
        chk_zero_geom("R5 geometry cleared");
    endtask

    task automatic t_unsupported();
        run(1'b0, 0, 8'hEC, 8'hBA, 8'h15, 1'b0);
        chk(result == 2'd2, "R8 bad maker", result, 2);
        chk_zero_geom("R8 geometry zero");
        run(1'b0, 0, 8'h2C, 8'hDA, 8'h15, 1'b0);
        chk(result == 2'd2, "R8 bad device", result, 2);
        run(1'b0, 0, 8'h2C, 8'hDA, 8'h16, 1'b0);
        chk(result == 2'd2, "R9 id check first", result, 2);
    endtask

    task automatic t_bad_geom();
        run(1'b0, 0, 8'h2C, 8'hBA, 8'h16, 1'b0);
        chk(result == 2'd3, "R9 page field", result, 3);
        chk_zero_geom("R9 geometry zero");
        run(1'b0, 0, 8'h2C, 8'hBA, 8'h11, 1'b0);
        chk(result == 2'd3, "R9 spare bit", result, 3);
        run(1'b0, 0, 8'h2C, 8'hBA, 8'h25, 1'b0);
        chk(result == 2'd3, "R9 block field", result, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_good_x8();
        t_hold();
        t_good_x16_nolimit();
        t_timeout();
        t_unsupported();
        t_bad_geom();
        t_good_x8();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule